// File: doc/BRIEF.md
# Line Pixel Statistics Engine

This block measures one colour line of a linear image sensor after digitisation. Pixel samples arrive as a stream. Each sample has a valid strobe and an active-region flag, and the line is framed by a start marker and an end marker. While the line runs, the engine keeps a running sum, the brightest and darkest sample, and two partial sums. One partial sum covers odd-numbered pixels and the other covers even-numbered pixels. The first active pixel of a line is number 1, so it is odd.

When the end marker arrives, the engine checks that exactly `NUM_PIX` active pixels were taken. A single shared sequential divider then computes the line average. It then computes the odd-versus-even difference of the per-parity averages, which shows how well matched the two readout paths of the sensor are. The largest deviation of any pixel from the average is derived from the held extremes. That one figure serves both the dark-level and the illuminated uniformity checks.

The results stay on the outputs with a valid flag until the consumer acknowledges them. A line that ends short raises an error flag instead of producing results. The states are:

- IDLE: waiting for a line.
- ACCUM: taking pixels.
- CLOSE: one cycle to judge the pixel count.
- DIV_AVG: dividing the sum by `NUM_PIX`.
- DIV_IMB: dividing the odd/even difference by `NUM_PIX/2`.
- DONE: results held.
- FAULT: short line reported.

The transitions are:

- A start marker moves the engine from any state to ACCUM.
- An end marker moves it from ACCUM to CLOSE.
- From CLOSE it goes to DIV_AVG when the count is full, and to FAULT when it is short.
- Divider completion moves it from DIV_AVG to DIV_IMB, and from DIV_IMB to DONE.
- An acknowledge moves it from DONE or FAULT back to IDLE.

Top module: `line_stats_engine`

## Requirements
- R1: After reset, `res_valid` and `line_err` are both 0.
- R2: A pixel is taken only when `in_vld` and `in_act` are both 1 during a line (state ACCUM, or the cycle carrying `in_sol`). Pixels with `in_act`=0, pixels outside a line, pixels after `in_eol`, and active pixels beyond the first `NUM_PIX` of a line have no effect on any result.
- R3: `res_avg` equals floor(sum of taken pixels / `NUM_PIX`).
- R4: `res_max` and `res_min` are the largest and smallest taken pixel values of the line.
- R5: `res_dev` equals the larger of (`res_max` - `res_avg`) and (`res_avg` - `res_min`).
- R6: `res_imb` is a two's complement value `PIX_W+1` bits wide. Its magnitude is floor(|S_odd - S_even| / (`NUM_PIX`/2)), and it is negative when S_even > S_odd. S_odd sums pixels 1, 3, 5, … and S_even sums pixels 2, 4, …, counting from 1 at the first taken pixel.
- R7: An `in_eol` with fewer than `NUM_PIX` taken pixels raises `line_err`, and `res_valid` stays 0. `line_err` holds until `res_ack`.
- R8: Once `res_valid` is 1, it and all result outputs stay unchanged until `res_ack` (or `in_sol`). The cycle after `res_ack`, `res_valid` is 0.
- R9: `in_sol` in any state discards the current line or held result and starts a new line with cleared accumulators. A pixel on the `in_sol` cycle is pixel 1. A pixel on the `in_eol` cycle is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sol | input | 1 | Start-of-line marker |
| in_eol | input | 1 | End-of-line marker |
| in_vld | input | 1 | Sample strobe |
| in_act | input | 1 | Sample lies in the active photocell region |
| in_data | input | PIX_W | Digitised pixel value |
| res_ack | input | 1 | Consumer acknowledges results or error |
| res_valid | output | 1 | Results are held and valid |
| line_err | output | 1 | Last line ended short |
| res_avg | output | PIX_W | Line average |
| res_max | output | PIX_W | Largest pixel |
| res_min | output | PIX_W | Smallest pixel |
| res_dev | output | PIX_W | Largest deviation from the average |
| res_imb | output | PIX_W+1 | Signed odd minus even average difference |

## Verification
Two functions of the engine can fall in the same cycle, and the bench provokes each pairing on purpose.

In the first pairing, the line boundary coincides with a pixel. The bench drives a line whose first pixel shares the cycle with `in_sol` and whose last pixel shares the cycle with `in_eol`. It judges the outcome by the average, the extremes and the sign of the imbalance. These match the model only if both edge pixels were counted with the correct parity.

In the second pairing, a restart meets held state. `in_sol` is issued in the middle of a line and again while results are still held without acknowledgement. The bench checks that `res_valid` drops and that the next results reflect only the new line.

// File: rtl/lse_pkg.sv
package lse_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_CLOSE,
        ST_DIV_AVG,
        ST_DIV_IMB,
        ST_DONE,
        ST_FAULT
    } lse_state_t;
endpackage

// File: rtl/line_accum.sv
module line_accum #(
    parameter int PIX_W   = 12,
    parameter int NUM_PIX = 10600,
    parameter int CNT_W   = $clog2(NUM_PIX + 1),
    parameter int ACC_W   = PIX_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [PIX_W-1:0] data,
    output logic [CNT_W-1:0] cnt_q,
    output logic [ACC_W-1:0] sum_q,
    output logic [ACC_W-1:0] odd_q,
    output logic [ACC_W-1:0] even_q,
    output logic [PIX_W-1:0] max_q,
    output logic [PIX_W-1:0] min_q
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_PIX);

    logic [CNT_W-1:0] cnt_b;
    logic [ACC_W-1:0] sum_b, odd_b, even_b, ext;
    logic [PIX_W-1:0] max_b, min_b;
    logic             use_px;

    always_comb begin
        cnt_b  = clr ? '0 : cnt_q;
        sum_b  = clr ? '0 : sum_q;
        odd_b  = clr ? '0 : odd_q;
        even_b = clr ? '0 : even_q;
        max_b  = clr ? '0 : max_q;
        min_b  = clr ? '1 : min_q;
        use_px = take && (cnt_b < LIMIT);
        ext    = {{(ACC_W-PIX_W){1'b0}}, data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sum_q  <= '0;
            odd_q  <= '0;
            even_q <= '0;
            max_q  <= '0;
            min_q  <= '1;
        end else begin
            cnt_q  <= use_px ? cnt_b + 1'b1 : cnt_b;
            sum_q  <= use_px ? sum_b + ext : sum_b;
            odd_q  <= (use_px && !cnt_b[0]) ? odd_b + ext : odd_b;
            even_q <= (use_px && cnt_b[0]) ? even_b + ext : even_b;
            max_q  <= (use_px && data > max_b) ? data : max_b;
            min_q  <= (use_px && data < min_b) ? data : min_b;
        end
    end

    // R2: the count of taken pixels never passes the line length
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R4: once a pixel is held, the extremes are ordered
    a_r4_extreme_order: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (min_q <= max_q));

    // R2: the odd and even partial sums always add up to the total
    a_r2_parity_split: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_q + even_q) == sum_q);
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);
    localparam int PW     = NUM_W + DEN_W;

    logic [NUM_W-1:0]  quo_q, num_q;
    logic [DEN_W-1:0]  den_q, rem_q;
    logic [STEP_W-1:0] step_q;
    logic              done_q;
    logic [DEN_W:0]    trial;
    logic              fits;
    logic [PW-1:0]     prod_chk, num_ext, den_ext;

    always_comb begin
        trial    = {rem_q, quo_q[NUM_W-1]};
        fits     = trial >= {1'b0, den_q};
        prod_chk = PW'(quo_q) * PW'(den_q);
        num_ext  = PW'(num_q);
        den_ext  = PW'(den_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            step_q <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            quo_q  <= num;
            num_q  <= num;
            den_q  <= den;
            rem_q  <= '0;
            step_q <= STEP_W'(NUM_W);
            done_q <= 1'b0;
        end else if (step_q != '0) begin
            rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            step_q <= step_q - 1'b1;
            done_q <= (step_q == STEP_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quo  = quo_q;

    // R3: a finished quotient is the floor of num over den
    a_r3_floor_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((prod_chk <= num_ext) && ((num_ext - prod_chk) < den_ext)));
endmodule

// File: rtl/line_stats_engine.sv
module line_stats_engine
    import lse_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int NUM_PIX = 10600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_sol,
    input  logic             in_eol,
    input  logic             in_vld,
    input  logic             in_act,
    input  logic [PIX_W-1:0] in_data,
    input  logic             res_ack,
    output logic             res_valid,
    output logic             line_err,
    output logic [PIX_W-1:0] res_avg,
    output logic [PIX_W-1:0] res_max,
    output logic [PIX_W-1:0] res_min,
    output logic [PIX_W-1:0] res_dev,
    output logic [PIX_W:0]   res_imb
);
    localparam int CNT_W = $clog2(NUM_PIX + 1);
    localparam int ACC_W = PIX_W + CNT_W;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_PIX);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(NUM_PIX / 2);

    lse_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] sum_q, odd_q, even_q, diff_abs, div_num, div_quo;
    logic [PIX_W-1:0] max_q, min_q, avg_q, dev_hi, dev_lo;
    logic [CNT_W-1:0] div_den;
    logic [PIX_W:0]   imb_q, imb_mag;
    logic             take, div_start, div_done, even_heavy, count_full;

    assign take       = in_vld && in_act && (in_sol || state_q == ST_ACCUM);
    assign count_full = (cnt_q == FULL_CNT);
    assign even_heavy = even_q > odd_q;
    assign diff_abs   = even_heavy ? even_q - odd_q : odd_q - even_q;
    assign div_start  = !in_sol && ((state_q == ST_CLOSE && count_full) ||
                                    (state_q == ST_DIV_AVG && div_done));
    assign div_num    = (state_q == ST_CLOSE) ? sum_q : diff_abs;
    assign div_den    = (state_q == ST_CLOSE) ? FULL_CNT : HALF_CNT;
    assign imb_mag    = {1'b0, div_quo[PIX_W-1:0]};

    line_accum #(.PIX_W(PIX_W), .NUM_PIX(NUM_PIX), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(in_sol), .take(take), .data(in_data),
        .cnt_q(cnt_q), .sum_q(sum_q), .odd_q(odd_q), .even_q(even_q),
        .max_q(max_q), .min_q(min_q)
    );

    seq_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
        .den(div_den), .done(div_done), .quo(div_quo)
    );

    always_comb begin
        state_d = state_q;
        if (in_sol) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ACCUM:   if (in_eol) state_d = ST_CLOSE;
                ST_CLOSE:   state_d = count_full ? ST_DIV_AVG : ST_FAULT;
                ST_DIV_AVG: if (div_done) state_d = ST_DIV_IMB;
                ST_DIV_IMB: if (div_done) state_d = ST_DONE;
                ST_DONE:    if (res_ack) state_d = ST_IDLE;
                ST_FAULT:   if (res_ack) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            avg_q   <= '0;
            imb_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DIV_AVG && div_done) avg_q <= div_quo[PIX_W-1:0];
            if (state_q == ST_DIV_IMB && div_done) imb_q <= even_heavy ? (~imb_mag + 1'b1) : imb_mag;
        end
    end

    always_comb begin
        dev_hi    = max_q - avg_q;
        dev_lo    = avg_q - min_q;
        res_valid = (state_q == ST_DONE);
        line_err  = (state_q == ST_FAULT);
        res_avg   = avg_q;
        res_max   = max_q;
        res_min   = min_q;
        res_dev   = (dev_hi > dev_lo) ? dev_hi : dev_lo;
        res_imb   = imb_q;
    end

    // R7: results and the short-line error never show together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && line_err));

    // R8: held results stay put until acknowledged or restarted
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack && !in_sol) |=>
        (res_valid && $stable(res_avg) && $stable(res_imb) && $stable(res_dev)));

    // R5: the average lies between the extremes and deviation is bounded by their span
    a_r5_dev_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_min <= res_avg) && (res_avg <= res_max) &&
                       (res_dev <= res_max - res_min)));

    // R9: a start marker drops any held result or error
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        in_sol |=> (!res_valid && !line_err));

    // R3: the average quotient always fits the pixel width
    a_r3_avg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV_AVG && div_done) |-> ((div_quo >> PIX_W) == '0));
endmodule

// File: tb/line_stats_engine_bench.sv
module line_stats_engine_bench;
    localparam int CLK_T = 10;
    localparam int PW    = 12;
    localparam int NPIX  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_sol = 0, in_eol = 0, in_vld = 0, in_act = 0, res_ack = 0;
    logic [PW-1:0] in_data = '0;
    logic res_valid, line_err;
    logic [PW-1:0] res_avg, res_max, res_min, res_dev;
    logic [PW:0] res_imb;

    int total = 0;
    int bad = 0;
    int pat [NPIX];
    int e_avg, e_max, e_min, e_dev, e_imb;

    always #(CLK_T/2) clk = ~clk;

    line_stats_engine #(.PIX_W(PW), .NUM_PIX(NPIX)) u_line_stats_engine (
        .clk(clk), .rst_n(rst_n), .in_sol(in_sol), .in_eol(in_eol),
        .in_vld(in_vld), .in_act(in_act), .in_data(in_data), .res_ack(res_ack),
        .res_valid(res_valid), .line_err(line_err), .res_avg(res_avg),
        .res_max(res_max), .res_min(res_min), .res_dev(res_dev), .res_imb(res_imb)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model();
        int s = 0, so = 0, se = 0, d;
        e_max = 0; e_min = 1 << PW;
        for (int i = 0; i < NPIX; i++) begin
            s += pat[i];
            if (i % 2 == 0) so += pat[i]; else se += pat[i];
            if (pat[i] > e_max) e_max = pat[i];
            if (pat[i] < e_min) e_min = pat[i];
        end
        e_avg = s / NPIX;
        e_dev = (e_max - e_avg > e_avg - e_min) ? e_max - e_avg : e_avg - e_min;
        d = so - se;
        e_imb = (d >= 0) ? d / (NPIX/2) : -((-d) / (NPIX/2));
    endtask

    task automatic drive_line(input bit m_sol, input bit m_eol, input bit gaps,
                              input int extra, input bit noise);
        if (noise) for (int k = 0; k < 3; k++) begin
            in_vld = 1; in_act = 1; in_data = '1; @(negedge clk);
        end
        in_vld = 0;
        if (!m_sol) begin in_sol = 1; @(negedge clk); in_sol = 0; end
        for (int i = 0; i < NPIX; i++) begin
            if (gaps && i % 4 == 2) begin
                in_vld = 1; in_act = 0; in_data = '1; @(negedge clk);
                in_vld = 0; in_act = 1; @(negedge clk);
            end
            in_vld = 1; in_act = 1; in_data = PW'(pat[i]);
            in_sol = m_sol && (i == 0);
            in_eol = m_eol && (extra == 0) && (i == NPIX-1);
            @(negedge clk);
            in_sol = 0; in_eol = 0;
        end
        for (int e = 0; e < extra; e++) begin
            in_vld = 1; in_act = 1; in_data = '1; @(negedge clk);
        end
        in_vld = 0;
        if (!m_eol || extra > 0) begin in_eol = 1; @(negedge clk); in_eol = 0; end
        if (noise) for (int k = 0; k < 4; k++) begin
            in_vld = 1; in_act = 1; in_data = '1; @(negedge clk);
        end
        in_vld = 0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 400; k++) begin
            if (res_valid || line_err) break;
            @(negedge clk);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R3 avg"}, int'(res_avg), e_avg);
        check({tag, " R4 max"}, int'(res_max), e_max);
        check({tag, " R4 min"}, int'(res_min), e_min);
        check({tag, " R5 dev"}, int'(res_dev), e_dev);
        check({tag, " R6 imb"}, int'($signed(res_imb)), e_imb);
    endtask

    task automatic ack();
        res_ack = 1; @(negedge clk); res_ack = 0;
        check("R8 valid cleared by ack", int'(res_valid), 0);
    endtask

    task automatic t_reset();
        check("R1 valid at reset", int'(res_valid), 0);
        check("R1 err at reset", int'(line_err), 0);
    endtask

    task automatic t_ramp_gaps();
        for (int i = 0; i < NPIX; i++) pat[i] = 100 + 37 * i;
        model();
        drive_line(0, 0, 1, 0, 1);
        wait_end();
        check("R2 ramp valid", int'(res_valid), 1);
        check_all("R2 ramp");
        ack();
    endtask

    task automatic t_odd_even(input bit odd_high);
        for (int i = 0; i < NPIX; i++) pat[i] = ((i % 2 == 0) == odd_high) ? 100 : 40;
        model();
        drive_line(0, 0, 0, 0, 0);
        wait_end();
        check_all(odd_high ? "R6 odd high" : "R6 even high");
        ack();
    endtask

    task automatic t_short();
        in_sol = 1; @(negedge clk); in_sol = 0;
        for (int i = 0; i < 5; i++) begin
            in_vld = 1; in_act = 1; in_data = 12'd50; @(negedge clk);
        end
        in_vld = 0; in_eol = 1; @(negedge clk); in_eol = 0;
        for (int k = 0; k < 60; k++) @(negedge clk);
        check("R7 err raised", int'(line_err), 1);
        check("R7 no results", int'(res_valid), 0);
        res_ack = 1; @(negedge clk); res_ack = 0;
        check("R7 err cleared", int'(line_err), 0);
    endtask

    task automatic t_hold_extra();
        int a, d, m;
        for (int i = 0; i < NPIX; i++) pat[i] = (i * 911 + 300) % 3000;
        model();
        drive_line(0, 0, 0, 3, 0);
        wait_end();
        check_all("R2 extras ignored");
        a = int'(res_avg); d = int'(res_dev); m = int'($signed(res_imb));
        for (int k = 0; k < 6; k++) @(negedge clk);
        check("R8 still valid", int'(res_valid), 1);
        check("R8 avg held", int'(res_avg), a);
        check("R8 dev held", int'(res_dev), d);
        check("R8 imb held", int'($signed(res_imb)), m);
        ack();
    endtask

    task automatic t_same_cycle();
        in_sol = 1; @(negedge clk); in_sol = 0;
        for (int i = 0; i < 7; i++) begin
            in_vld = 1; in_act = 1; in_data = 12'd4000; @(negedge clk);
        end
        in_vld = 0;
        for (int i = 0; i < NPIX; i++) pat[i] = 500 + ((i % 2 == 0) ? 2 * i : 0);
        pat[0] = 5; pat[NPIX-1] = 3900;
        model();
        drive_line(1, 1, 0, 0, 0);
        wait_end();
        check_all("R9 sol/eol merged");
    endtask

    task automatic t_sol_over_done();
        check("R9 prior result held", int'(res_valid), 1);
        in_sol = 1; @(negedge clk); in_sol = 0;
        check("R9 result dropped", int'(res_valid), 0);
        for (int i = 0; i < NPIX; i++) pat[i] = 2000 - 13 * i;
        model();
        drive_line(1, 0, 0, 0, 0);
        wait_end();
        check_all("R9 after restart");
        ack();
    endtask

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ramp_gaps();
        t_odd_even(1);
        t_odd_even(0);
        t_short();
        t_hold_extra();
        t_same_cycle();
        t_sol_over_done();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule